// File: doc/BRIEF.md
# Carrier Cycle Counter with Epoch Latch

This block serves one tracking channel of a satellite navigation correlator. It counts the overflow pulses of the channel's carrier numerically-controlled oscillator, one pulse per completed carrier cycle, over each measurement epoch. Epochs are marked by a single-cycle epoch pulse. On each epoch pulse the running count is split into a coarse cycle word and a fine two-bit phase field, both are captured into output registers, and counting restarts from zero.

Software reads the captured values after each epoch. A protect flag rises with each captured epoch and guards the captured values until the trailing edge of a read of the cycle word. If another epoch arrives while the flag is still up, the captured values are kept, the counter still restarts, and an overrun bit records the lost epoch. The cycle word must therefore be read last among the channel's measurement registers.

With the default 18-bit counter, the block holds more than the roughly 203,000 carrier cycles that fit in a 100 ms epoch at the highest carrier rate, with margin for Doppler.

Top module: `carrier_cycle_latch`

## Requirements
- R1: While reset is applied and after it is released, the cycle output, phase output, protect flag and overrun bit are all zero.
- R2: Between epoch pulses, each cycle with `ovf_pulse` high adds exactly one to the running count. Cycles with `ovf_pulse` low add nothing.
- R3: On an accepted epoch pulse, bits [CNT_W-1:2] of the count go to `cycle_word` and bits [1:0] go to `fine_phase`. Both are visible on the clock edge that samples the pulse.
- R4: After an epoch pulse the count restarts at zero. An overflow pulse in the same cycle as the epoch pulse is included in the captured value and not carried into the next epoch.
- R5: The count saturates at all ones; further overflow pulses leave it there until the next epoch pulse.
- R6: `cycle_word` and `fine_phase` change only on an accepted epoch pulse.
- R7: `protect` is set by every epoch pulse. It is cleared on the clock edge that samples `rd_cycle` low one cycle after it was high, which is the trailing edge of a cycle-word read.
- R8: An epoch pulse while `protect` is set, without a trailing edge in the same cycle, is not accepted. The captured values are held, `overrun` is set, and the count still restarts.
- R9: A trailing edge clears `overrun`. A trailing edge in the same cycle as an epoch pulse lets that pulse be accepted, leaves `protect` set, and leaves `overrun` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ovf_pulse | input | 1 | Carrier oscillator overflow, one cycle per carrier cycle |
| epoch_pulse | input | 1 | Measurement epoch marker, one cycle wide |
| rd_cycle | input | 1 | High while software reads the cycle word |
| cycle_word | output | CNT_W-2 | Captured coarse carrier cycle count |
| fine_phase | output | 2 | Captured two low bits of the count |
| protect | output | 1 | Captured data awaiting read |
| overrun | output | 1 | An epoch was refused while protected |

## Verification
The hardest conditions to reach are counter saturation and the collisions of an epoch pulse with an overflow pulse, with a held protect flag, and with a read trailing edge in the same cycle. The bench builds the design with a 10-bit counter, so a long run of back-to-back overflow pulses reaches saturation in about a thousand cycles. It then places the epoch pulse deliberately on the cycle of the last overflow pulse and on the cycle right after a read strobe falls. A free-running behavioural model compares every output on every clock, so each collision is judged against the rule it must follow.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
  // Number of count bits that form the fine phase field
  localparam int unsigned FINE_W = 2;

  typedef enum logic [1:0] {
    GRD_IDLE    = 2'b00,
    GRD_HELD    = 2'b01,
    GRD_OVERRUN = 2'b11
  } grd_state_e;
endpackage

// File: rtl/ccl_rst_sync.sv
module ccl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ccl_upcounter.sv
module ccl_upcounter #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_full;
  logic             cnt_en;

  always_comb begin
    cnt_full = (cnt_q == CNT_MAX);
    cnt_inc  = (ovf_i && !cnt_full) ? cnt_q + 1'b1 : cnt_q;
    cnt_en   = restart_i | (ovf_i & ~cnt_full);
    cnt_d    = restart_i ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // value including any pulse of this cycle, offered to the capture stage
  assign snap_o = cnt_inc;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0)); // R4
  AST_SATURATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !restart_i) |=> (cnt_q == CNT_MAX)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !ovf_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/ccl_capture.sv
module ccl_capture #(
  parameter int unsigned CNT_W = 18
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_i,
  input  logic [CNT_W-1:0]                   snap_i,
  output logic [CNT_W-ccl_pkg::FINE_W-1:0]   cycle_o,
  output logic [ccl_pkg::FINE_W-1:0]         phase_o
);
  localparam int unsigned FW = ccl_pkg::FINE_W;
  localparam int unsigned CW = CNT_W - FW;

  logic [CW-1:0] cycle_q, cycle_d;
  logic [FW-1:0] phase_q, phase_d;

  always_comb begin
    cycle_d = snap_i[CNT_W-1:FW];
    phase_d = snap_i[FW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_q <= '0;
      phase_q <= '0;
    end else if (load_i) begin
      cycle_q <= cycle_d;
      phase_q <= phase_d;
    end
  end

  assign cycle_o = cycle_q;
  assign phase_o = phase_q;

  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(cycle_q) && $stable(phase_q))); // R6
endmodule

// File: rtl/ccl_guard.sv
module ccl_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic tic_i,
  input  logic rd_i,
  output logic load_o,
  output logic protect_o,
  output logic overrun_o
);
  import ccl_pkg::*;

  logic       rd_q;
  logic       release_w;
  grd_state_e st_q, st_d;
  logic       held;

  always_comb begin
    release_w = rd_q & ~rd_i;
    held      = (st_q != GRD_IDLE);
    load_o    = tic_i & (~held | release_w);
    st_d      = st_q;
    if (tic_i) begin
      if (held && !release_w) st_d = GRD_OVERRUN;
      else                    st_d = GRD_HELD;
    end else if (release_w) begin
      st_d = GRD_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      st_q <= GRD_IDLE;
    end else begin
      rd_q <= rd_i;
      st_q <= st_d;
    end
  end

  assign protect_o = held;
  assign overrun_o = (st_q == GRD_OVERRUN);

  AST_TIC_PROTECTS: assert property (@(posedge clk) disable iff (!rst_n)
    tic_i |=> protect_o); // R7
  AST_REFUSED_TIC: assert property (@(posedge clk) disable iff (!rst_n)
    (tic_i && protect_o && !release_w) |=> overrun_o); // R8
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (release_w && !tic_i) |=> (!protect_o && !overrun_o)); // R9
endmodule

// File: rtl/carrier_cycle_latch.sv
module carrier_cycle_latch #(
  parameter int unsigned CNT_W = 18
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ovf_pulse,
  input  logic                               epoch_pulse,
  input  logic                               rd_cycle,
  output logic [CNT_W-ccl_pkg::FINE_W-1:0]   cycle_word,
  output logic [ccl_pkg::FINE_W-1:0]         fine_phase,
  output logic                               protect,
  output logic                               overrun
);
  logic             rst_n_i;
  logic             load_w;
  logic [CNT_W-1:0] snap_w;

  ccl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  ccl_upcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .ovf_i(ovf_pulse),
    .restart_i(epoch_pulse), .snap_o(snap_w)
  );

  ccl_guard u_grd (
    .clk(clk), .rst_n(rst_n_i), .tic_i(epoch_pulse), .rd_i(rd_cycle),
    .load_o(load_w), .protect_o(protect), .overrun_o(overrun)
  );

  ccl_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n_i), .load_i(load_w), .snap_i(snap_w),
    .cycle_o(cycle_word), .phase_o(fine_phase)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_i |=> (!protect && !overrun)); // R1
endmodule

// File: tb/tb_carrier_cycle_latch.sv
module tb_carrier_cycle_latch;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 10;
  localparam int FW  = 2;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovf = 1'b0, tic = 1'b0, rd = 1'b0;
  logic [W-FW-1:0] cyc;
  logic [FW-1:0]   ph;
  logic prot, ovr;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_cyc = 0, m_ph = 0;
  bit m_prot = 0, m_ovr = 0, m_rdd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carrier_cycle_latch #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf), .epoch_pulse(tic),
    .rd_cycle(rd), .cycle_word(cyc), .fine_phase(ph),
    .protect(prot), .overrun(ovr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: count, accept rule, release rule
  always @(posedge clk) begin
    int inc;
    bit rel;
    if (!rst_n) begin
      m_cnt = 0; m_cyc = 0; m_ph = 0; m_prot = 0; m_ovr = 0; m_rdd = 0;
    end else begin
      rel = m_rdd && !rd;
      inc = (ovf && m_cnt < MAXC) ? m_cnt + 1 : m_cnt;
      if (tic) begin
        if (!m_prot || rel) begin
          m_cyc = inc / 4;
          m_ph  = inc % 4;
        end
        if (m_prot && !rel) m_ovr = 1;
        else if (rel)       m_ovr = 0;
        m_prot = 1;
        m_cnt  = 0;
      end else begin
        m_cnt = inc;
        if (rel) begin m_prot = 0; m_ovr = 0; end
      end
      m_rdd = rd;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 cycle_word", int'(cyc), m_cyc);
      chk("R3 fine_phase", int'(ph), m_ph);
      chk("R7 protect", int'(prot), int'(m_prot));
      chk("R8 overrun", int'(ovr), int'(m_ovr));
    end
  end

  task automatic drive(input bit o, input bit t, input bit r);
    @(negedge clk); #1;
    ovf = o; tic = t; rd = r;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0);
    drive(0, 0, 0);
  endtask

  task automatic read_cycle();
    drive(0, 0, 1);
    drive(0, 0, 0);
    drive(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cycle", int'(cyc), 0);
    chk("R1 reset protect", int'(prot), 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset overrun", int'(ovr), 0);
    cmp_en = 1'b1;

    // R2/R3: 5 pulses -> cycle 1 phase 1
    pulses(5);
    drive(0, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R2 count of five cycle", int'(cyc), 1);
    chk("R2 count of five phase", int'(ph), 1);
    read_cycle();
    chk("R7 released", int'(prot), 0);

    // R4: pulse coincident with tic counted; next epoch starts from zero
    pulses(2);
    drive(1, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R4 coincident phase", int'(ph), 3);
    read_cycle();
    drive(0, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R4 restart zero", int'(cyc) * 4 + int'(ph), 0);
    read_cycle();

    // R8: tic while protected -> held, overrun; counter still restarted
    pulses(9);
    drive(0, 1, 0);
    pulses(6);
    drive(0, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R8 held cycle", int'(cyc), 2);
    chk("R8 overrun set", int'(ovr), 1);
    chk("R6 phase unchanged", int'(ph), 1);
    read_cycle();
    chk("R9 overrun cleared", int'(ovr), 0);

    // R9: release coincides with tic -> accepted, no overrun
    pulses(3);
    drive(0, 1, 0);
    pulses(7);
    drive(0, 0, 1);
    drive(0, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R9 accepted phase", int'(ph), 3);
    chk("R9 no overrun", int'(ovr), 0);
    chk("R9 still protected", int'(prot), 1);
    read_cycle();

    // R5: saturation
    pulses(MAXC + 20);
    drive(0, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R5 saturated", int'(cyc) * 4 + int'(ph), MAXC);
    read_cycle();

    // R6: many pulses without tic leave latch alone
    pulses(13);
    chk("R6 no change w/o tic", int'(cyc), MAXC / 4);
    drive(0, 1, 0); drive(0, 0, 0);
    @(negedge clk);
    chk("R2 count after saturation", int'(cyc) * 4 + int'(ph), 13);
    read_cycle();

    // mixed pattern
    for (int k = 0; k < 300; k++)
      drive(((k * 7) % 3) != 0, (k % 37) == 36, (k % 23) == 5);
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule